// File: doc/BRIEF.md
# Bit-Mask Generation Unit

This unit derives a bit mask from a single source word. A 4-bit control field sets three things. It chooses the source or its complement as the first addend. It chooses +1 or -1 as the second addend. It fixes the entries of a small truth table. Each result bit comes from that table, indexed by the matching source bit and the matching bit of the sum. The same datapath therefore yields the common lowest-set-bit masks: isolate, clear, fill-below and fill-through.

The control values whose truth table is all zeros are rejected. The unit raises an illegal flag for them, so those control values stay free for other uses. The inputs are captured on a clock edge while the input strobe is high. The result, its valid strobe and the illegal flag come out of registers one cycle later.

Top module: `bmask_unit`

## Requirements
- R1: When control bit 0 is 1, the first addend is the bitwise complement of the source; otherwise it is the source itself.
- R2: When control bit 1 is 1, the second addend is +1; otherwise it is all ones (-1).
- R3: The intermediate word y is the sum of the two addends modulo 2^WIDTH, with no carry-in, and any carry out of the top bit is dropped.
- R4: Result bit i is a table lookup at index {src[i], y[i]}. Index 0 gives 0, indices 1 and 2 give control bit 2, and index 3 gives control bit 3. So control bits [3:2] = 01 produce src XOR y, 11 produce src OR y, and 10 produce src AND y.
- R5: When control bits [3:2] are both 0, a captured request sets the illegal flag in the next cycle, and the result word is 0.
- R6: A request captured with the input strobe high shows its result and a high result-valid exactly one cycle later.
- R7: In a cycle after the input strobe was low, result-valid and the illegal flag are low and the result word keeps its previous value.
- R8: A synchronous active-high reset clears the result word, result-valid and the illegal flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; inputs are captured while it is high |
| src | input | WIDTH | Source word |
| ctrl | input | 4 | Control: [0] complement, [1] +1/-1, [2] table entries 1 and 2, [3] table entry 3 |
| res | output | WIDTH | Registered mask result |
| res_valid | output | 1 | Result valid, one cycle after the request |
| illegal | output | 1 | Control encoding has an all-zero table |

## Verification
The assertions assume that the input strobe, the source and the control are stable and defined at each rising edge. They also assume that reset is asserted on the first edge, so the registered outputs start from a known state. The stimulus changes inputs only on falling edges and starts with reset held for several cycles. It covers every one of the 16 control values with the strobe high. The idle cycles, the reset in mid-stream and the reserved encodings are exercised at the same boundaries the properties watch.

// File: rtl/bmask_unit.sv
module bmask_unit #(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] src,
  input  logic [3:0]       ctrl,
  output logic [WIDTH-1:0] res,
  output logic             res_valid,
  output logic             illegal
);

  logic [WIDTH-1:0] opa, opb, sum, mask;
  logic [3:0]       lut;
  logic             reserved;

  assign opa      = ctrl[0] ? ~src : src;
  assign opb      = ctrl[1] ? WIDTH'(1) : {WIDTH{1'b1}};
  assign sum      = opa + opb;
  assign lut      = {ctrl[3], ctrl[2], ctrl[2], 1'b0};
  assign reserved = ~(ctrl[3] | ctrl[2]);

  for (genvar i = 0; i < WIDTH; i++) begin : g_sel
    assign mask[i] = lut[{src[i], sum[i]}];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res       <= '0;
      res_valid <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      res_valid <= in_valid;
      illegal   <= in_valid & reserved;
      if (in_valid) res <= reserved ? '0 : mask;
    end
  end

endmodule

module bmask_unit_chk #(
  parameter int WIDTH = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [WIDTH-1:0] src,
  input logic [3:0]       ctrl,
  input logic [WIDTH-1:0] res,
  input logic             res_valid,
  input logic             illegal
);

  // R5
  reserved_flag_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && ctrl[3:2] == 2'b00 |=> illegal && res == '0);

  // R5
  legal_flag_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && ctrl[3:2] != 2'b00 |=> !illegal);

  // R6
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid);

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !res_valid && !illegal && $stable(res));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !res_valid && !illegal && res == '0);

  // R4
  zero_src_xor_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && src == '0 && ctrl == 4'b0100 |=> res == {WIDTH{1'b1}});

endmodule

bind bmask_unit bmask_unit_chk #(.WIDTH(WIDTH)) chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .src(src), .ctrl(ctrl),
  .res(res), .res_valid(res_valid), .illegal(illegal)
);

// File: tb/bmask_unit_test.sv
module bmask_unit_test;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] src = '0;
  logic [3:0]   ctrl = '0;
  logic [W-1:0] res;
  logic         res_valid, illegal;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [W-1:0] m_res = '0;
  logic         m_valid = 0, m_ill = 0;
  string        m_tag = "R8";

  always #10 clk = ~clk;

  bmask_unit #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src(src), .ctrl(ctrl),
    .res(res), .res_valid(res_valid), .illegal(illegal)
  );

  function automatic logic [W-1:0] ref_mask(logic [W-1:0] s, logic [3:0] c);
    logic [W-1:0] a, y;
    a = c[0] ? ~s : s;               // R1
    y = c[1] ? a + 1 : a - 1;        // R2, R3
    case (c[3:2])                    // R4
      2'b01:   return s ^ y;
      2'b11:   return s | y;
      2'b10:   return s & y;
      default: return '0;            // R5
    endcase
  endfunction

  task automatic compare();
    checks++;
    if (res !== m_res || res_valid !== m_valid || illegal !== m_ill) begin
      failures++;
      $display("FAIL %s: res=%h valid=%b ill=%b expected res=%h valid=%b ill=%b",
               m_tag, res, res_valid, illegal, m_res, m_valid, m_ill);
    end
  endtask

  task automatic step(input logic r, input logic v, input logic [W-1:0] s,
                      input logic [3:0] c);
    @(negedge clk);
    compare();
    rst = r; in_valid = v; src = s; ctrl = c;
    if (r) begin
      m_res = '0; m_valid = 0; m_ill = 0; m_tag = "R8";
    end else if (v) begin
      m_valid = 1;
      m_ill = (c[3:2] == 2'b00);
      m_res = ref_mask(s, c);
      m_tag = m_ill ? "R5" : (c[0] ? "R1/R4" : (c[1] ? "R2/R4" : "R3/R4"));
    end else begin
      m_valid = 0; m_ill = 0; m_tag = "R7";
    end
  endtask

  initial begin
    logic [W-1:0] pat [8];
    pat[0] = '0; pat[1] = '1; pat[2] = W'(1); pat[3] = W'(1) << 31;
    pat[4] = W'(1) << (W-1); pat[5] = 64'h00F0_0000_0000_0100;
    pat[6] = 64'h8000_0000_0000_0001; pat[7] = 64'h5555_AAAA_0F0F_F0F0;
    repeat (3) step(1, 0, '0, '0);   // R8 reset state
    for (int c = 0; c < 16; c++) begin
      for (int p = 0; p < 8; p++) step(0, 1, pat[p], 4'(c));  // R6 back to back
      step(0, 0, $urandom, 4'(c));   // R7 idle holds result
      for (int k = 0; k < 20; k++)
        step(0, 1, {$urandom, $urandom}, 4'(c));
    end
    // R3 wrap: all ones + 1, zero - 1
    step(0, 1, '1, 4'b1110);
    step(0, 1, '0, 4'b1100);
    step(1, 1, '1, 4'b0111);         // R8 reset mid-stream wins over valid
    step(0, 0, '0, 4'b0000);
    for (int k = 0; k < 300; k++)
      step(0, ($urandom % 4) != 0, {$urandom, $urandom}, 4'($urandom));
    step(0, 0, '0, '0);
    step(0, 0, '0, '0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule